// File: doc/BRIEF.md
# Configurable Port Pin Bank

This block implements an eight-pin general-purpose port on a microcontroller's synchronous register bus. Every pin has its own output-value bit, direction bit and address-capture bit.

The address-capture bit takes the low multiplexed address/data line while the address-latch-enable input is high. One port-wide select decides what each pin drives: the output-value register, or the captured low address byte. A second port-wide option sets the drive style for all pins:

- **Push-pull:** the pin drives both levels.
- **Open-drain:** the pin only pulls low. A high value releases the pin.

Software sees three byte-wide locations, each read separately:

- **Offset 0:** the live pin levels. This location is read-only.
- **Offset 1:** the output-value register.
- **Offset 2:** the direction register.

Writes are sampled on the rising clock edge that sees the write strobe. Reads are combinational.

Top module: `port_pin_bank`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, the output-value, direction and address-capture registers are all zero, so every `padOe` bit is 0 and reads of offsets 1 and 2 return 0.
- R2: A write strobe with `busAddr` = 1 loads `busWData` into the output-value register at that clock edge. Afterwards a read of offset 1 returns it.
- R3: A write strobe with `busAddr` = 2 loads `busWData` into the direction register at that clock edge. Afterwards a read of offset 2 returns it. A direction bit of 1 means output.
- R4: A read of offset 0 returns the current `padIn` value. A write to offset 0 changes neither the output-value nor the direction register.
- R5: With `openDrain` = 0, `padOe` equals the direction register and `padOut` equals the selected source byte.
- R6: With `openDrain` = 1, `padOut` is all zeros. Each `padOe` bit is 1 only where the direction bit is 1 and the source bit is 0.
- R7: At each rising edge where `ale` is 1, the address-capture register loads `adIn`. While `ale` is 0 it holds its value.
- R8: The source byte is the address-capture register when `addrSel` = 1, and the output-value register when `addrSel` = 0.
- R9: `busRData` is zero when `busRd` is 0 or when `busAddr` = 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busAddr | input | 2 | Register offset |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWData | input | 8 | Write data |
| busRData | output | 8 | Read data (combinational) |
| ale | input | 1 | Address latch enable |
| adIn | input | 8 | Low multiplexed address/data bits |
| addrSel | input | 1 | 1: pins drive the captured address |
| openDrain | input | 1 | 1: open-drain output style |
| padIn | input | 8 | Pin levels seen at the pads |
| padOut | output | 8 | Value driven toward the pads |
| padOe | output | 8 | Per-pin output enable |

## Verification
Pin outputs and read data are combinational from the current state and inputs, so they are due in the same cycle as the inputs that produce them. The bench drives new inputs on the falling edge and samples one nanosecond later, before the next rising edge.

Register writes and address captures take effect at the following rising edge. The bench's model registers update only after that edge, so the first cycle that can show a new value is the next one. The directed R7 sequence holds `ale` low over several cycles to show that the captured byte survives a changing `adIn`.

// File: rtl/port_pin_pkg.sv
package port_pin_pkg;
  localparam int ADDR_W = 2;
  localparam logic [ADDR_W-1:0] OFF_PIN  = 2'd0;
  localparam logic [ADDR_W-1:0] OFF_DATA = 2'd1;
  localparam logic [ADDR_W-1:0] OFF_DIR  = 2'd2;

  typedef struct packed {
    logic wrData;
    logic wrDir;
    logic rdPin;
    logic rdData;
    logic rdDir;
    logic capAddr;
  } portStrobes_t;
endpackage

// File: rtl/port_pin_ctrl.sv
module port_pin_ctrl
  import port_pin_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic              ale,
  output portStrobes_t      strobes
);
  logic hitPin, hitData, hitDir;

  always_comb begin
    hitPin  = (busAddr == OFF_PIN);
    hitData = (busAddr == OFF_DATA);
    hitDir  = (busAddr == OFF_DIR);
  end

  always_comb begin
    strobes.wrData  = busWr & hitData;
    strobes.wrDir   = busWr & hitDir;
    strobes.rdPin   = busRd & hitPin;
    strobes.rdData  = busRd & hitData;
    strobes.rdDir   = busRd & hitDir;
    strobes.capAddr = ale;
  end
endmodule

// File: rtl/port_pin_datapath.sv
module port_pin_datapath
  import port_pin_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  portStrobes_t     strobes,
  input  logic [WIDTH-1:0] busWData,
  input  logic [WIDTH-1:0] adIn,
  input  logic             addrSel,
  input  logic             openDrain,
  input  logic [WIDTH-1:0] padIn,
  output logic [WIDTH-1:0] padOut,
  output logic [WIDTH-1:0] padOe,
  output logic [WIDTH-1:0] busRData,
  output logic [WIDTH-1:0] dataQ,
  output logic [WIDTH-1:0] dirQ,
  output logic [WIDTH-1:0] addrQ
);
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ <= '0;
      dirQ  <= '0;
      addrQ <= '0;
    end else begin
      if (strobes.wrData)  dataQ <= busWData;
      if (strobes.wrDir)   dirQ  <= busWData;
      if (strobes.capAddr) addrQ <= adIn;
    end
  end

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    logic srcBit;
    always_comb begin
      srcBit = addrSel ? addrQ[i] : dataQ[i];
      if (openDrain) begin
        padOut[i] = 1'b0;
        padOe[i]  = dirQ[i] & ~srcBit;
      end else begin
        padOut[i] = srcBit;
        padOe[i]  = dirQ[i];
      end
    end
  end

  always_comb begin
    busRData = '0;
    if (strobes.rdPin)  busRData = padIn;
    if (strobes.rdData) busRData = dataQ;
    if (strobes.rdDir)  busRData = dirQ;
  end
endmodule

// File: rtl/port_pin_bank.sv
module port_pin_bank
  import port_pin_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [WIDTH-1:0]  busWData,
  output logic [WIDTH-1:0]  busRData,
  input  logic              ale,
  input  logic [WIDTH-1:0]  adIn,
  input  logic              addrSel,
  input  logic              openDrain,
  input  logic [WIDTH-1:0]  padIn,
  output logic [WIDTH-1:0]  padOut,
  output logic [WIDTH-1:0]  padOe
);
  portStrobes_t     strobes;
  logic [WIDTH-1:0] dataQ, dirQ, addrQ;

  port_pin_ctrl u_ctrl (
    .busAddr(busAddr), .busWr(busWr), .busRd(busRd), .ale(ale),
    .strobes(strobes)
  );

  port_pin_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busWData(busWData),
    .adIn(adIn), .addrSel(addrSel), .openDrain(openDrain), .padIn(padIn),
    .padOut(padOut), .padOe(padOe), .busRData(busRData),
    .dataQ(dataQ), .dirQ(dirQ), .addrQ(addrQ)
  );
endmodule

// File: rtl/port_pin_chk.sv
module port_pin_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [1:0]       busAddr,
  input logic             busWr,
  input logic [WIDTH-1:0] busWData,
  input logic             ale,
  input logic [WIDTH-1:0] adIn,
  input logic             openDrain,
  input logic [WIDTH-1:0] padOut,
  input logic [WIDTH-1:0] padOe,
  input logic [WIDTH-1:0] dataQ,
  input logic [WIDTH-1:0] dirQ,
  input logic [WIDTH-1:0] addrQ
);
  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rstN |=> (dataQ == '0 && dirQ == '0 && addrQ == '0));
  // R2
  data_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd1) |=> dataQ == $past(busWData));
  // R3
  dir_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd2) |=> dirQ == $past(busWData));
  // R4
  pin_wr_ignored_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busWr && busAddr == 2'd0) |=> ($stable(dataQ) && $stable(dirQ)));
  // R7
  addr_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    ale |=> addrQ == $past(adIn));
  // R7
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !ale |=> $stable(addrQ));
  // R6
  od_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    openDrain |-> (padOut == '0 && (padOe & ~dirQ) == '0));
endmodule

bind port_pin_bank port_pin_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr),
  .busWData(busWData), .ale(ale), .adIn(adIn), .openDrain(openDrain),
  .padOut(padOut), .padOe(padOe), .dataQ(dataQ), .dirQ(dirQ), .addrQ(addrQ)
);

// File: tb/test_port_pin_bank.sv
`timescale 1ns/1ps
module test_port_pin_bank;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic       busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWData = '0, busRData;
  logic       ale = 1'b0;
  logic [7:0] adIn = '0;
  logic       addrSel = 1'b0, openDrain = 1'b0;
  logic [7:0] padIn = '0, padOut, padOe;

  int checks = 0;
  int errors = 0;
  logic [7:0] mData = '0, mDir = '0, mAddr = '0;

  always #2.5 clk = ~clk;

  port_pin_bank i_port_pin_bank (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWData(busWData), .busRData(busRData), .ale(ale), .adIn(adIn),
    .addrSel(addrSel), .openDrain(openDrain), .padIn(padIn),
    .padOut(padOut), .padOe(padOe)
  );

  function automatic logic [7:0] expSrc();
    return addrSel ? mAddr : mData;
  endfunction
  function automatic logic [7:0] expOe();
    return openDrain ? (mDir & ~expSrc()) : mDir;
  endfunction
  function automatic logic [7:0] expOut();
    return openDrain ? 8'h00 : expSrc();
  endfunction
  function automatic logic [7:0] expRd();
    if (!busRd) return 8'h00;
    case (busAddr)
      2'd0: return padIn;
      2'd1: return mData;
      2'd2: return mDir;
      default: return 8'h00;
    endcase
  endfunction

  task automatic chk(input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic checkAll();
    string rtag;
    string otag;
    rtag = !busRd ? "R9" : busAddr == 2'd0 ? "R4" : busAddr == 2'd1 ? "R2" :
           busAddr == 2'd2 ? "R3" : "R9";
    otag = addrSel ? "R8" : (openDrain ? "R6" : "R5");
    chk(openDrain ? "R6" : "R5", "padOe", padOe, expOe());
    chk(otag, "padOut", padOut, expOut());
    chk(rtag, "busRData", busRData, expRd());
  endtask

  task automatic advance();
    @(posedge clk);
    if (busWr && busAddr == 2'd1) mData = busWData;
    if (busWr && busAddr == 2'd2) mDir = busWData;
    if (ale) mAddr = adIn;
  endtask

  task automatic cycle(input logic [1:0] a, input logic w, input logic r,
                       input logic [7:0] wd, input logic l, input logic [7:0] ad,
                       input logic sel, input logic od, input logic [7:0] pin);
    @(negedge clk);
    busAddr = a; busWr = w; busRd = r; busWData = wd; ale = l; adIn = ad;
    addrSel = sel; openDrain = od; padIn = pin;
    #1 checkAll();
    advance();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    // R1: state while reset is held
    busWr = 1'b1; busAddr = 2'd2; busWData = 8'hFF; ale = 1'b1; adIn = 8'hAA;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "padOe in reset", padOe, 8'h00);
    busWr = 1'b0; ale = 1'b0; busRd = 1'b1; busAddr = 2'd1;
    #1 chk("R1", "data readback in reset", busRData, 8'h00);
    busAddr = 2'd2;
    #1 chk("R1", "dir readback in reset", busRData, 8'h00);
    rstN = 1'b1;

    // R2 and R3: directed writes, then readback
    cycle(2'd1, 1, 0, 8'h5A, 0, 8'h00, 0, 0, 8'h00);
    cycle(2'd2, 1, 0, 8'hF0, 0, 8'h00, 0, 0, 8'h00);
    cycle(2'd1, 0, 1, 8'h00, 0, 8'h00, 0, 0, 8'h00);
    cycle(2'd2, 0, 1, 8'h00, 0, 8'h00, 0, 1, 8'h00);

    // R4: a write to the pin offset leaves both registers unchanged
    cycle(2'd0, 1, 1, 8'h33, 0, 8'h00, 0, 0, 8'hC3);
    cycle(2'd1, 0, 1, 8'h00, 0, 8'h00, 0, 0, 8'h00);
    chk("R4", "data after pin write", busRData, 8'h5A);
    cycle(2'd2, 0, 1, 8'h00, 0, 8'h00, 0, 0, 8'h00);
    chk("R4", "dir after pin write", busRData, 8'hF0);

    // R9: the unused offset reads zero
    cycle(2'd3, 0, 1, 8'h00, 0, 8'h00, 0, 0, 8'hFF);
    chk("R9", "unused offset", busRData, 8'h00);

    // R7: capture, then hold while adIn changes
    cycle(2'd2, 1, 0, 8'hFF, 1, 8'h96, 1, 0, 8'h00);
    for (int k = 0; k < 4; k++) begin
      cycle(2'd0, 0, 0, 8'h00, 0, 8'h0F + 8'(k), 1, 0, 8'h00);
      chk("R7", "held address", padOut, 8'h96);
    end
    // R6 and R8: open-drain driven from the captured address
    cycle(2'd0, 0, 0, 8'h00, 0, 8'h00, 1, 1, 8'h00);
    chk("R6", "od oe from address", padOe, 8'h69);

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      cycle(2'($urandom_range(0, 3)), ($urandom_range(0, 2) == 0),
            1'($urandom_range(0, 1)), 8'($urandom), 1'($urandom_range(0, 1)),
            8'($urandom), 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            8'($urandom));
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule